// File: doc/BRIEF.md
# SPI Status and Error Flag Controller

This block keeps the status and control byte of a serial peripheral interface. It tracks four conditions: receive-full, overflow, mode-fault and transmit-empty. It also stores the software-set error interrupt enable, the mode-fault detect enable and a two-bit baud-select code. The code goes out to a baud divider that lives elsewhere. A shift engine outside the block reports when a byte has been received, when the transmit byte has been taken, and the slave-select pin level. The processor bus reports strobes for status reads and writes, data register reads and writes, and control register writes.

A flag is never cleared by writing to it. Each of the receive-full, overflow and mode-fault flags has its own armed bit. A status read that returns the flag as 1 sets that armed bit. A later clearing access then removes only the flags that were armed. For receive-full and overflow, that access is a data read. For mode-fault, it is a control register write.

When a byte arrives while the receive register still holds an unread byte, the block withholds the receive-register load strobe. The older byte is kept and overflow is raised. The block drives the receive and error interrupt request lines from the flags and their enables.

Top module: `spi_stat_ctl`

## Requirements
- R1: The status byte on `stat_rdata` uses these bit positions: 7 receive-full, 6 error interrupt enable, 5 overflow, 4 mode-fault, 3 transmit-empty, 2 mode-fault enable, 1..0 baud select.
- R2: After reset the status byte reads 0x08: only transmit-empty is 1. Both interrupt requests are 0 and `baud_sel` is 0.
- R3: `byte_done` sets receive-full one cycle later. Receive-full clears after a status read that saw it at 1, followed by a `data_rd`.
- R4: `rx_irq` is 1 exactly when receive-full is 1 and `rx_irq_en` is 1.
- R5: If `byte_done` arrives while receive-full is 1 and is not being cleared in that cycle, overflow sets and `rxbuf_load` stays 0. Otherwise `rxbuf_load` follows `byte_done`.
- R6: Overflow clears after a status read that saw it at 1, followed by a `data_rd`.
- R7: Mode-fault detection only acts while mode-fault enable is 1. A slave (`master_mode`=0) sets mode-fault on a low-to-high change of `ss_in` while `xfer_active` is 1. A master sets it on any high-to-low change of `ss_in`.
- R8: Mode-fault clears after a status read that saw it at 1, followed by a `ctl_wr`. A `ctl_wr` without that read leaves it set.
- R9: `err_irq` is 1 when error interrupt enable is 1 and overflow or mode-fault is 1. It is 0 whenever the enable is 0.
- R10: A clearing access clears only flags that were armed by an earlier status read. A flag that set after that read, or a clearing access with no prior read, leaves the flag at 1.
- R11: `stat_wr` loads only bits 6, 2, 1 and 0 from `wdata`. Values written to bits 7, 5, 4 and 3 are ignored.
- R12: `data_wr` clears transmit-empty. `tx_loaded` sets it again. If both occur in the same cycle, transmit-empty is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stat_rd | input | 1 | Status register read strobe |
| stat_wr | input | 1 | Status register write strobe |
| data_rd | input | 1 | Data register read strobe |
| data_wr | input | 1 | Data register write strobe |
| ctl_wr | input | 1 | Control register write strobe |
| wdata | input | 8 | Bus write data |
| byte_done | input | 1 | Shift engine has a complete received byte |
| tx_loaded | input | 1 | Shift engine moved the transmit byte into the shifter |
| ss_in | input | 1 | Slave-select pin level |
| xfer_active | input | 1 | A transfer is in progress |
| master_mode | input | 1 | 1 = master, 0 = slave |
| rx_irq_en | input | 1 | Receive interrupt enable from the control register |
| stat_rdata | output | 8 | Status byte |
| baud_sel | output | 2 | Baud-select code |
| rxbuf_load | output | 1 | Strobe to load the receive data register |
| rx_irq | output | 1 | Receive interrupt request |
| err_irq | output | 1 | Error interrupt request |

## Verification
The assertions check on every cycle that each flag falls only after its own clearing access. They check that overflow can only rise while receive-full was set, and that the receive load strobe is withheld exactly when the receive register is full. They also check that neither interrupt request is raised without its flag. Only the directed scenarios can show the full two-step ordering. That includes a flag setting between the status read and the clearing access and surviving it, and a clearing access with no prior read doing nothing. The scenarios also cover the different slave-select edge rules in master and slave mode, and that writes to flag positions are ignored.

// File: rtl/spi_sts_pkg.sv
package spi_sts_pkg;
  localparam int NFLAG = 3;
  localparam int FL_RF = 0;
  localparam int FL_OV = 1;
  localparam int FL_MF = 2;
  localparam int STAT_W = 8;
  localparam int BAUD_W = 2;

  typedef struct packed {
    logic              errie;
    logic              modfen;
    logic [BAUD_W-1:0] baud;
  } cfg_t;
endpackage

// File: rtl/spi_sts_flag.sv
module spi_sts_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic stat_rd_i,
  input  logic clr_acc_i,
  output logic flag_o,
  output logic clr_o
);
  logic flag_q, flag_n;
  logic arm_q, arm_n;
  logic clr;

  assign clr = clr_acc_i & arm_q;

  always_comb begin
    flag_n = set_i | (flag_q & ~clr);
    arm_n  = arm_q & ~clr_acc_i;
    if (stat_rd_i && flag_q) arm_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      flag_q <= flag_n;
      arm_q  <= arm_n;
    end
  end

  assign flag_o = flag_q;
  assign clr_o  = clr;
endmodule

// File: rtl/spi_sts_cfg.sv
module spi_sts_cfg
  import spi_sts_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [STAT_W-1:0] wdata,
  output cfg_t              cfg_o
);
  cfg_t cfg_q, cfg_n;

  always_comb begin
    cfg_n = cfg_q;
    if (wr_en) begin
      cfg_n.errie  = wdata[6];
      cfg_n.modfen = wdata[2];
      cfg_n.baud   = wdata[BAUD_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_n;
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/spi_sts_ssmon.sv
module spi_sts_ssmon (
  input  logic clk,
  input  logic rst_n,
  input  logic ss_in,
  input  logic xfer_active,
  input  logic master_mode,
  input  logic det_en,
  output logic fault_o
);
  logic ss_q;
  logic rise, fall;

  assign rise = ss_in & ~ss_q;
  assign fall = ~ss_in & ss_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ss_q <= 1'b1;
    else        ss_q <= ss_in;
  end

  always_comb begin
    if (!det_en)          fault_o = 1'b0;
    else if (master_mode) fault_o = fall;
    else                  fault_o = rise & xfer_active;
  end
endmodule

// File: rtl/spi_stat_ctl.sv
module spi_stat_ctl
  import spi_sts_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stat_rd,
  input  logic              stat_wr,
  input  logic              data_rd,
  input  logic              data_wr,
  input  logic              ctl_wr,
  input  logic [STAT_W-1:0] wdata,
  input  logic              byte_done,
  input  logic              tx_loaded,
  input  logic              ss_in,
  input  logic              xfer_active,
  input  logic              master_mode,
  input  logic              rx_irq_en,
  output logic [STAT_W-1:0] stat_rdata,
  output logic [BAUD_W-1:0] baud_sel,
  output logic              rxbuf_load,
  output logic              rx_irq,
  output logic              err_irq
);
  cfg_t             cfg;
  logic             mf_evt;
  logic [NFLAG-1:0] set_v, clracc_v, flag_v, clr_v;
  logic             rx_full_hold;
  logic             te_q, te_n;

  spi_sts_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(stat_wr), .wdata(wdata), .cfg_o(cfg)
  );

  spi_sts_ssmon u_ssmon (
    .clk(clk), .rst_n(rst_n), .ss_in(ss_in), .xfer_active(xfer_active),
    .master_mode(master_mode), .det_en(cfg.modfen), .fault_o(mf_evt)
  );

  // receive register stays full this cycle unless it is being cleared
  assign rx_full_hold = flag_v[FL_RF] & ~clr_v[FL_RF];
  assign rxbuf_load   = byte_done & ~rx_full_hold;

  always_comb begin
    set_v              = '0;
    set_v[FL_RF]       = byte_done;
    set_v[FL_OV]       = byte_done & rx_full_hold;
    set_v[FL_MF]       = mf_evt;
    clracc_v           = '0;
    clracc_v[FL_RF]    = data_rd;
    clracc_v[FL_OV]    = data_rd;
    clracc_v[FL_MF]    = ctl_wr;
  end

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    spi_sts_flag u_flag (
      .clk(clk), .rst_n(rst_n), .set_i(set_v[g]), .stat_rd_i(stat_rd),
      .clr_acc_i(clracc_v[g]), .flag_o(flag_v[g]), .clr_o(clr_v[g])
    );
  end

  always_comb begin
    te_n = te_q;
    if (tx_loaded) te_n = 1'b1;
    if (data_wr)   te_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) te_q <= 1'b1;
    else        te_q <= te_n;
  end

  assign stat_rdata = {flag_v[FL_RF], cfg.errie, flag_v[FL_OV], flag_v[FL_MF],
                       te_q, cfg.modfen, cfg.baud};
  assign baud_sel   = cfg.baud;
  assign rx_irq     = flag_v[FL_RF] & rx_irq_en;
  assign err_irq    = cfg.errie & (flag_v[FL_OV] | flag_v[FL_MF]);
endmodule

// File: rtl/spi_stat_ctl_chk.sv
module spi_stat_ctl_chk
  import spi_sts_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              stat_rd,
  input logic              stat_wr,
  input logic              data_rd,
  input logic              data_wr,
  input logic              ctl_wr,
  input logic [STAT_W-1:0] wdata,
  input logic              byte_done,
  input logic              tx_loaded,
  input logic              ss_in,
  input logic              xfer_active,
  input logic              master_mode,
  input logic              rx_irq_en,
  input logic [STAT_W-1:0] stat_rdata,
  input logic [BAUD_W-1:0] baud_sel,
  input logic              rxbuf_load,
  input logic              rx_irq,
  input logic              err_irq
);
  AST_RF_CLEAR_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat_rdata[7]) |-> $past(data_rd)); // R3
  AST_RX_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> stat_rdata[7]); // R4
  AST_NO_OVERFLOW_WITHOUT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_rdata[5]) |-> $past(stat_rdata[7]) && $past(byte_done)); // R5
  AST_LOAD_ONLY_ON_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    rxbuf_load |-> byte_done); // R5
  AST_LOAD_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && !stat_rdata[7]) |-> rxbuf_load); // R5
  AST_OV_CLEAR_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat_rdata[5]) |-> $past(data_rd)); // R6
  AST_MF_CLEAR_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat_rdata[4]) |-> $past(ctl_wr)); // R8
  AST_MF_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_rdata[4]) |-> $past(stat_rdata[2])); // R7
  AST_ERR_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_rdata[6] |-> !err_irq); // R9
  AST_TE_CLEAR_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat_rdata[3]) |-> $past(data_wr)); // R12
  AST_BAUD_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(stat_wr) |-> $stable(baud_sel)); // R11
endmodule

bind spi_stat_ctl spi_stat_ctl_chk chk_i (.*);

// File: tb/spi_stat_ctl_tb_top.sv
module spi_stat_ctl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stat_rd = 0, stat_wr = 0, data_rd = 0, data_wr = 0, ctl_wr = 0;
  logic [7:0] wdata = '0;
  logic byte_done = 0, tx_loaded = 0, ss_in = 1, xfer_active = 0;
  logic master_mode = 0, rx_irq_en = 0;
  logic [7:0] stat_rdata;
  logic [1:0] baud_sel;
  logic rxbuf_load, rx_irq, err_irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  spi_stat_ctl dut_i (.*);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic flags(input string tag, input logic [7:0] exp);
    chk(tag, int'(stat_rdata & 8'hB8), int'(exp));
  endtask

  task automatic tick();
    @(posedge clk); #1;
    stat_rd = 0; stat_wr = 0; data_rd = 0; data_wr = 0; ctl_wr = 0;
    byte_done = 0; tx_loaded = 0;
  endtask

  task automatic t_reset();
    chk("R2 status", int'(stat_rdata), 8'h08);
    chk("R2 baud", int'(baud_sel), 0);
    chk("R2 irqs", int'({rx_irq, err_irq}), 0);
  endtask

  task automatic t_cfg();
    stat_wr = 1; wdata = 8'hFF; tick();
    chk("R11 R1 write ones", int'(stat_rdata), 8'h4F);
    chk("R11 baud", int'(baud_sel), 3);
    stat_wr = 1; wdata = 8'hB9; tick();
    chk("R11 flag bits ignored", int'(stat_rdata), 8'h09);
    stat_wr = 1; wdata = 8'h44; tick();
    chk("R11 errie modfen", int'(stat_rdata), 8'h4C);
  endtask

  task automatic t_rx();
    byte_done = 1; #1;
    chk("R5 load when empty", int'(rxbuf_load), 1);
    tick();
    flags("R3 rf set", 8'h88);
    rx_irq_en = 1; #1;
    chk("R4 rx_irq on", int'(rx_irq), 1);
    rx_irq_en = 0; #1;
    chk("R4 rx_irq gated", int'(rx_irq), 0);
    data_rd = 1; tick();
    flags("R10 no read no clear", 8'h88);
    stat_rd = 1; tick();
    data_rd = 1; tick();
    flags("R3 rf cleared", 8'h08);
  endtask

  task automatic t_ovf();
    byte_done = 1; tick();
    byte_done = 1; #1;
    chk("R5 load withheld", int'(rxbuf_load), 0);
    tick();
    flags("R5 overflow set", 8'hA8);
    chk("R9 err_irq", int'(err_irq), 1);
    stat_wr = 1; wdata = 8'h04; tick();
    chk("R9 err_irq gated", int'(err_irq), 0);
    stat_wr = 1; wdata = 8'h44; tick();
    stat_rd = 1; tick();
    data_rd = 1; tick();
    flags("R6 overflow cleared", 8'h08);
  endtask

  task automatic t_arm();
    byte_done = 1; tick();
    stat_rd = 1; tick();
    byte_done = 1; tick();
    flags("R10 ov set after read", 8'hA8);
    data_rd = 1; tick();
    flags("R10 unarmed ov kept", 8'h28);
    stat_rd = 1; tick();
    data_rd = 1; tick();
    flags("R6 ov cleared later", 8'h08);
  endtask

  task automatic t_mf();
    master_mode = 0; xfer_active = 1;
    ss_in = 0; tick();
    flags("R7 slave fall ignored", 8'h08);
    ss_in = 1; tick();
    flags("R7 slave rise in xfer", 8'h18);
    chk("R9 err_irq mf", int'(err_irq), 1);
    ctl_wr = 1; tick();
    flags("R8 no read no clear", 8'h18);
    stat_rd = 1; tick();
    data_rd = 1; tick();
    flags("R8 data read no clear", 8'h18);
    ctl_wr = 1; tick();
    flags("R8 mf cleared", 8'h08);
    xfer_active = 0; ss_in = 0; tick(); ss_in = 1; tick();
    flags("R7 slave rise idle", 8'h08);
    master_mode = 1; ss_in = 0; tick();
    flags("R7 master fall", 8'h18);
    stat_rd = 1; tick(); ctl_wr = 1; tick();
    stat_wr = 1; wdata = 8'h40; ss_in = 1; tick();
    ss_in = 0; tick();
    flags("R7 detect disabled", 8'h08);
    ss_in = 1; master_mode = 0; tick();
  endtask

  task automatic t_tx();
    data_wr = 1; tick();
    flags("R12 te cleared", 8'h00);
    tx_loaded = 1; tick();
    flags("R12 te set", 8'h08);
    tx_loaded = 1; data_wr = 1; tick();
    flags("R12 write wins", 8'h00);
    tx_loaded = 1; tick();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_cfg();
    t_rx();
    t_ovf();
    t_arm();
    t_mf();
    t_tx();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule